// File: doc/BRIEF.md
# Write-Back Set-Associative Data Cache with Freeze and Bypass Modes

This block sits between a processor data port and an external memory port. Requests to cacheable addresses are served from a write-back, four-way set-associative store. Each line holds 128 bytes, and a miss brings the whole line in as a burst of word beats. Every request is first classified by a bank of 256 cacheability bits. Each bit covers one 16 MB slice of the 4 GB address space. Accesses to slices whose bit is clear are passed to external memory one word at a time and are never allocated.

A run-time mode register changes how the store behaves:
- In normal mode, misses allocate a line.
- In freeze mode, hits are still served but a miss neither allocates nor evicts, so resident lines survive a burst of one-time traffic.
- In bypass mode, every access goes to external memory and the resident lines are left exactly as they were, so they are found again when normal mode returns.

The processor holds a request until a one-cycle done pulse. The external side moves one word per ready handshake.

Top module: `setassoc_cache`

## Requirements
- R1: After reset all lines are invalid, every cacheability bit is 0 and the mode is normal (0), so the first read of any address is a single external read beat.
- R2: The cacheability bit for region i (address bits [31:24] equal to i) is written and read at configuration byte offset 4*i, `cfgAddr[9:2]` selecting the region; each bit holds its own value independently of the others.
- R3: An access to a region whose bit is 0 makes exactly one external word transfer (read or write), allocates nothing, and a repeat of it is again external.
- R4: A cacheable read miss in normal mode reads the full 128-byte line as 32 word beats at ascending addresses from the line base (address with bits [6:0] cleared), then returns the requested word.
- R5: A cacheable read hit returns the stored word with no external transfer.
- R6: A cacheable write hit updates only the cached copy (no external transfer); later reads of that word return the new value.
- R7: When the chosen victim line is dirty, its 32 words are written back at ascending addresses from its own line base before the new line is fetched; a clean victim causes no write beats.
- R8: Each set holds 4 lines indexed by address bits [8:7] and replaces them round-robin, way 0 first, so the fifth distinct line in a set evicts the first one allocated there.
- R9: In freeze mode (1), hits behave as in normal mode, a read miss is one external read beat, and a write miss is one external write beat; no line is allocated or evicted.
- R10: In bypass mode (2), every access is one external transfer, reads return external memory contents even for resident lines, and resident lines, dirty data included, are still present after returning to normal mode.
- R11: Mode encodings are 0 normal, 1 freeze, 2 bypass; a write of 3 is ignored and the mode keeps its previous value.
- R12: The external request holds its address, direction and write data stable until `memReady`, exactly one word moves per cycle with both high, and addresses are word aligned.
- R13: `reqDone` is a single-cycle pulse, `rspData` carries the read word while it is high, and no external request is active during it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Processor request, held until reqDone |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqAddr | input | 32 | Byte address of the word |
| reqWdata | input | DATA_W | Store data |
| reqDone | output | 1 | One-cycle completion pulse |
| rspData | output | DATA_W | Load data, valid with reqDone |
| cfgWe | input | 1 | Write strobe for a cacheability bit |
| cfgAddr | input | REGION_BITS+2 | Byte offset of the cacheability register |
| cfgWdata | input | 1 | Bit value to write |
| cfgRdata | output | 1 | Bit value at cfgAddr |
| modeWe | input | 1 | Write strobe for the mode register |
| modeIn | input | 2 | New mode value |
| modeOut | output | 2 | Current mode |
| memReq | output | 1 | External transfer request |
| memWrite | output | 1 | External transfer is a write |
| memAddr | output | 32 | External word address (byte-addressed) |
| memWdata | output | DATA_W | External write data |
| memRdata | input | DATA_W | External read data |
| memReady | input | 1 | External beat accepted |

## Verification
The assertions check, on every cycle, the external handshake rules: a request stays stable until ready, and addresses are aligned. They also check that the done pulse lasts one cycle with the external port quiet, and that the mode register never holds the unused code. Allocation, victim choice, write-back ordering, and whether freeze and bypass preserve contents are matters of history across many requests. Only the bench scenarios show these, by counting external beats per request, logging burst addresses, and comparing returned words with values computed from the access sequence.

// File: rtl/cache_pkg.sv
package cache_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_FREEZE = 2'd1,
    MODE_BYPASS = 2'd2
  } cacheMode_e;

  typedef enum logic [1:0] {
    ADDR_REQ  = 2'd0,
    ADDR_WB   = 2'd1,
    ADDR_FILL = 2'd2
  } addrSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     latchReq;
    logic     cpuWrite;
    logic     fillWrite;
    logic     installLine;
    logic     beatInc;
    logic     beatClr;
    logic     rspFromCache;
    logic     rspFromMem;
    addrSel_e addrSel;
  } ctrlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic cacheable;
    logic hit;
    logic isWrite;
    logic freeze;
    logic victimDirty;
    logic lastBeat;
  } dpStatus_t;

endpackage

// File: rtl/cache_datapath.sv
module cache_datapath
  import cache_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int LINE_BYTES  = 128,
  parameter int SETS        = 4,
  parameter int WAYS        = 4,
  parameter int REGION_BITS = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobe_t            st,
  output dpStatus_t              stat,
  input  logic                   reqWrite,
  input  logic [31:0]            reqAddr,
  input  logic [DATA_W-1:0]      reqWdata,
  output logic [DATA_W-1:0]      rspData,
  input  logic                   cfgWe,
  input  logic [REGION_BITS+1:0] cfgAddr,
  input  logic                   cfgWdata,
  output logic                   cfgRdata,
  input  logic                   modeWe,
  input  logic [1:0]             modeIn,
  output logic [1:0]             modeOut,
  output logic [31:0]            memAddr,
  output logic [DATA_W-1:0]      memWdata,
  input  logic [DATA_W-1:0]      memRdata
);
  localparam int BYTES_PER_WORD = DATA_W / 8;
  localparam int WORDS   = LINE_BYTES / BYTES_PER_WORD;
  localparam int BYTE_W  = $clog2(BYTES_PER_WORD);
  localparam int WORD_W  = $clog2(WORDS);
  localparam int OFF_W   = BYTE_W + WORD_W;
  localparam int SET_W   = $clog2(SETS);
  localparam int WAY_W   = $clog2(WAYS);
  localparam int TAG_W   = 32 - OFF_W - SET_W;
  localparam int LINES   = SETS * WAYS;
  localparam int ENTRIES = LINES * WORDS;
  localparam int REGIONS = 1 << REGION_BITS;

  // latched request
  logic [31:0]       reqAddrQ;
  logic [DATA_W-1:0] reqWdataQ;
  logic              reqWriteQ;

  // storage
  logic [TAG_W-1:0]  tagArr  [LINES];
  logic [WAYS-1:0]   validQ  [SETS];
  logic [WAYS-1:0]   dirtyQ  [SETS];
  logic [WAY_W-1:0]  rrQ     [SETS];
  logic [DATA_W-1:0] dataArr [ENTRIES];
  logic [REGIONS-1:0] regionQ;
  cacheMode_e        modeQ;
  logic [WORD_W-1:0] beatQ;
  logic [DATA_W-1:0] rspQ;

  logic [SET_W-1:0]  setIdx;
  logic [TAG_W-1:0]  tagQ;
  logic [WORD_W-1:0] wordIdx;
  assign setIdx  = reqAddrQ[OFF_W +: SET_W];
  assign tagQ    = reqAddrQ[31 -: TAG_W];
  assign wordIdx = reqAddrQ[BYTE_W +: WORD_W];

  logic [WAYS-1:0]  wayHit;
  logic [WAY_W-1:0] hitWay;
  logic [WAY_W-1:0] victimWay;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign wayHit[w] = validQ[setIdx][w] &&
                       (tagArr[{setIdx, WAY_W'(w)}] == tagQ);
  end

  always_comb begin
    hitWay = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (wayHit[w]) hitWay = WAY_W'(w);
    end
  end

  assign victimWay = rrQ[setIdx];

  logic [SET_W+WAY_W+WORD_W-1:0] cpuEntry, beatEntry;
  assign cpuEntry  = {setIdx, hitWay, wordIdx};
  assign beatEntry = {setIdx, victimWay, beatQ};

  assign stat.cacheable   = regionQ[reqAddrQ[31 -: REGION_BITS]] && (modeQ != MODE_BYPASS);
  assign stat.hit         = |wayHit;
  assign stat.isWrite     = reqWriteQ;
  assign stat.freeze      = (modeQ == MODE_FREEZE);
  assign stat.victimDirty = validQ[setIdx][victimWay] && dirtyQ[setIdx][victimWay];
  assign stat.lastBeat    = (beatQ == WORD_W'(WORDS - 1));

  always_comb begin
    unique case (st.addrSel)
      ADDR_WB:   memAddr = {tagArr[{setIdx, victimWay}], setIdx, beatQ, BYTE_W'(0)};
      ADDR_FILL: memAddr = {tagQ, setIdx, beatQ, BYTE_W'(0)};
      default:   memAddr = {reqAddrQ[31:BYTE_W], BYTE_W'(0)};
    endcase
  end

  assign memWdata = (st.addrSel == ADDR_WB) ? dataArr[beatEntry] : reqWdataQ;
  assign rspData  = rspQ;
  assign cfgRdata = regionQ[cfgAddr[REGION_BITS+1:2]];
  assign modeOut  = modeQ;

  // control state of the arrays
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        validQ[s] <= '0;
        dirtyQ[s] <= '0;
        rrQ[s]    <= '0;
      end
      regionQ <= '0;
      modeQ   <= MODE_NORMAL;
      beatQ   <= '0;
    end else begin
      if (st.cpuWrite) dirtyQ[setIdx][hitWay] <= 1'b1;
      if (st.installLine) begin
        validQ[setIdx][victimWay] <= 1'b1;
        dirtyQ[setIdx][victimWay] <= 1'b0;
        rrQ[setIdx]               <= victimWay + 1'b1;
      end
      if (st.beatClr)      beatQ <= '0;
      else if (st.beatInc) beatQ <= beatQ + 1'b1;
      if (cfgWe) regionQ[cfgAddr[REGION_BITS+1:2]] <= cfgWdata;
      if (modeWe && modeIn != 2'd3) modeQ <= cacheMode_e'(modeIn);
    end
  end

  // payload registers, no reset needed
  always_ff @(posedge clk) begin
    if (st.latchReq) begin
      reqAddrQ  <= reqAddr;
      reqWdataQ <= reqWdata;
      reqWriteQ <= reqWrite;
    end
    if (st.installLine)  tagArr[{setIdx, victimWay}] <= tagQ;
    if (st.cpuWrite)     dataArr[cpuEntry] <= reqWdataQ;
    if (st.fillWrite)    dataArr[beatEntry] <= memRdata;
    if (st.rspFromCache) rspQ <= dataArr[cpuEntry];
    else if (st.rspFromMem) rspQ <= memRdata;
  end

endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
  import cache_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  dpStatus_t   stat,
  input  logic        memReady,
  output ctrlStrobe_t st,
  output logic        memReq,
  output logic        memWrite,
  output logic        reqDone
);
  typedef enum logic [2:0] {
    S_IDLE, S_LOOK, S_WB, S_FILL, S_SINGLE, S_DONE
  } state_e;

  state_e stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= S_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD   = stateQ;
    st       = '0;
    st.addrSel = ADDR_REQ;
    memReq   = 1'b0;
    memWrite = 1'b0;
    reqDone  = 1'b0;
    unique case (stateQ)
      S_IDLE: begin
        if (reqValid) begin
          st.latchReq = 1'b1;
          stateD      = S_LOOK;
        end
      end
      S_LOOK: begin
        if (stat.cacheable && stat.hit) begin
          st.rspFromCache = 1'b1;
          st.cpuWrite     = stat.isWrite;
          stateD          = S_DONE;
        end else if (stat.cacheable && !stat.freeze) begin
          st.beatClr = 1'b1;
          stateD     = stat.victimDirty ? S_WB : S_FILL;
        end else begin
          stateD = S_SINGLE;
        end
      end
      S_WB: begin
        st.addrSel = ADDR_WB;
        memReq     = 1'b1;
        memWrite   = 1'b1;
        if (memReady) begin
          st.beatInc = 1'b1;
          if (stat.lastBeat) begin
            st.beatClr = 1'b1;
            stateD     = S_FILL;
          end
        end
      end
      S_FILL: begin
        st.addrSel = ADDR_FILL;
        memReq     = 1'b1;
        if (memReady) begin
          st.fillWrite = 1'b1;
          st.beatInc   = 1'b1;
          if (stat.lastBeat) begin
            st.installLine = 1'b1;
            stateD         = S_LOOK;
          end
        end
      end
      S_SINGLE: begin
        memReq   = 1'b1;
        memWrite = stat.isWrite;
        if (memReady) begin
          st.rspFromMem = 1'b1;
          stateD        = S_DONE;
        end
      end
      S_DONE: begin
        reqDone = 1'b1;
        stateD  = S_IDLE;
      end
      default: stateD = S_IDLE;
    endcase
  end

endmodule

// File: rtl/setassoc_cache.sv
module setassoc_cache
  import cache_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int LINE_BYTES  = 128,
  parameter int SETS        = 4,
  parameter int WAYS        = 4,
  parameter int REGION_BITS = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  input  logic                   reqWrite,
  input  logic [31:0]            reqAddr,
  input  logic [DATA_W-1:0]      reqWdata,
  output logic                   reqDone,
  output logic [DATA_W-1:0]      rspData,
  input  logic                   cfgWe,
  input  logic [REGION_BITS+1:0] cfgAddr,
  input  logic                   cfgWdata,
  output logic                   cfgRdata,
  input  logic                   modeWe,
  input  logic [1:0]             modeIn,
  output logic [1:0]             modeOut,
  output logic                   memReq,
  output logic                   memWrite,
  output logic [31:0]            memAddr,
  output logic [DATA_W-1:0]      memWdata,
  input  logic [DATA_W-1:0]      memRdata,
  input  logic                   memReady
);
  ctrlStrobe_t st;
  dpStatus_t   stat;

  cache_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .stat     (stat),
    .memReady (memReady),
    .st       (st),
    .memReq   (memReq),
    .memWrite (memWrite),
    .reqDone  (reqDone)
  );

  cache_datapath #(
    .DATA_W      (DATA_W),
    .LINE_BYTES  (LINE_BYTES),
    .SETS        (SETS),
    .WAYS        (WAYS),
    .REGION_BITS (REGION_BITS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .st       (st),
    .stat     (stat),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .rspData  (rspData),
    .cfgWe    (cfgWe),
    .cfgAddr  (cfgAddr),
    .cfgWdata (cfgWdata),
    .cfgRdata (cfgRdata),
    .modeWe   (modeWe),
    .modeIn   (modeIn),
    .modeOut  (modeOut),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .memRdata (memRdata)
  );

endmodule

// File: rtl/setassoc_cache_chk.sv
module setassoc_cache_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqDone,
  input logic              memReq,
  input logic              memReady,
  input logic              memWrite,
  input logic [31:0]       memAddr,
  input logic [DATA_W-1:0] memWdata,
  input logic [1:0]        modeOut
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    reqDone |=> !reqDone); // R13

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    reqDone |-> !memReq); // R13

  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> (memReq && $stable(memAddr) && $stable(memWrite) && $stable(memWdata))); // R12

  AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memAddr[1:0] == 2'b00)); // R12

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    modeOut != 2'd3); // R11
endmodule

bind setassoc_cache setassoc_cache_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqDone  (reqDone),
  .memReq   (memReq),
  .memReady (memReady),
  .memWrite (memWrite),
  .memAddr  (memAddr),
  .memWdata (memWdata),
  .modeOut  (modeOut)
);

// File: tb/setassoc_cache_bench.sv
`timescale 1ns/1ps
module setassoc_cache_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [31:0] reqAddr = '0, reqWdata = '0;
  logic        reqDone;
  logic [31:0] rspData;
  logic        cfgWe = 1'b0, cfgWdata = 1'b0, cfgRdata;
  logic [9:0]  cfgAddr = '0;
  logic        modeWe = 1'b0;
  logic [1:0]  modeIn = '0, modeOut;
  logic        memReq, memWrite;
  logic [31:0] memAddr, memWdata, memRdata;
  logic        memReady;

  always #2 clk = ~clk;

  setassoc_cache u_setassoc_cache (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqDone(reqDone), .rspData(rspData),
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata), .cfgRdata(cfgRdata),
    .modeWe(modeWe), .modeIn(modeIn), .modeOut(modeOut),
    .memReq(memReq), .memWrite(memWrite), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memReady(memReady)
  );

  // external memory model
  logic [31:0] mem [0:8191];
  logic [31:0] rdLog [0:63];
  logic [31:0] wrLog [0:63];
  int unsigned rdTotal = 0, wrTotal = 0;

  function automatic int unsigned idxOf(input logic [31:0] a);
    return int'({a[30], a[13:2]});
  endfunction

  function automatic logic [31:0] initVal(input logic [31:0] a);
    return idxOf(a) * 32'h0001_0003 + 32'h1234;
  endfunction

  assign memRdata = mem[idxOf(memAddr)];

  always @(posedge clk) begin
    if (!rstN) memReady <= 1'b0;
    else begin
      memReady <= memReq && !memReady;
      if (memReq && memReady) begin
        if (memWrite) begin
          mem[idxOf(memAddr)] <= memWdata;
          wrLog[wrTotal % 64] <= memAddr;
          wrTotal <= wrTotal + 1;
        end else begin
          rdLog[rdTotal % 64] <= memAddr;
          rdTotal <= rdTotal + 1;
        end
      end
    end
  end

  int checks = 0, fails = 0;
  logic [31:0] lastRd;
  int unsigned rdBeats, wrBeats, rdBase, wrBase;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [31:0] a, input logic [31:0] wd);
    int n = 0;
    @(negedge clk);
    rdBase = rdTotal; wrBase = wrTotal;
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = wd;
    do begin
      @(negedge clk);
      n++;
    end while (!reqDone && n < 3000);
    lastRd = rspData;
    reqValid = 1'b0;
    rdBeats = rdTotal - rdBase;
    wrBeats = wrTotal - wrBase;
    if (n >= 3000) chk("R13 request timeout", 32'd0, 32'd1);
  endtask

  task automatic expectBeats(input string req, input int unsigned r, input int unsigned w);
    chk(req, {rdBeats[15:0], wrBeats[15:0]}, {r[15:0], w[15:0]});
  endtask

  // count burst address mismatches against ascending line order
  function automatic int burstErrs(input bit isWr, input int unsigned base, input logic [31:0] lineBase);
    int e = 0;
    for (int k = 0; k < 32; k++) begin
      logic [31:0] got;
      got = isWr ? wrLog[(base + k) % 64] : rdLog[(base + k) % 64];
      if (got != lineBase + 32'(k * 4)) e++;
    end
    return e;
  endfunction

  task automatic setRegion(input int i, input logic v);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = 10'(i * 4); cfgWdata = v;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic setMode(input logic [1:0] m);
    @(negedge clk);
    modeWe = 1'b1; modeIn = m;
    @(negedge clk);
    modeWe = 1'b0;
  endtask

  function automatic logic [31:0] lineA(input int k);
    return 32'h8000_0000 + 32'(k * 32'h200);
  endfunction

  initial begin
    #(4 * 150000);
    fails++; checks++;
    $display("FAIL R12 watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int errs;
    for (int i = 0; i < 8192; i++) mem[i] = int'(i) * 32'h0001_0003 + 32'h1234;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 mode after reset", 32'(modeOut), 32'd0);
    cfgAddr = 10'h200; #1;
    chk("R1 region bit after reset", 32'(cfgRdata), 32'd0);
    chk("R1 done idle", 32'(reqDone), 32'd0);
    access(1'b0, lineA(0), 32'd0);
    expectBeats("R1 first read single beat", 1, 0);
    chk("R1 first read data", lastRd, initVal(lineA(0)));
    @(negedge clk);
    chk("R13 done drops after one cycle", 32'(reqDone), 32'd0);

    // R2 sweep over all cacheability registers
    for (int i = 0; i < 256; i++) setRegion(i, logic'((i ^ (i >> 3)) & 1));
    errs = 0;
    for (int i = 0; i < 256; i++) begin
      cfgAddr = 10'(i * 4); #1;
      if (cfgRdata !== logic'((i ^ (i >> 3)) & 1)) errs++;
    end
    chk("R2 region readback sweep errors", 32'(errs), 32'd0);
    for (int i = 0; i < 256; i++) setRegion(i, 1'b0);
    setRegion(8'h80, 1'b1);
    errs = 0;
    for (int i = 0; i < 256; i++) begin
      cfgAddr = 10'(i * 4); #1;
      if (cfgRdata !== (i == 8'h80)) errs++;
    end
    chk("R2 single bit isolation errors", 32'(errs), 32'd0);

    // R4 read miss fills full line
    access(1'b0, lineA(0) + 32'h14, 32'd0);
    expectBeats("R4 miss burst beats", 32, 0);
    chk("R4 burst ascending order errors", 32'(burstErrs(1'b0, rdBase, lineA(0))), 32'd0);
    chk("R4 miss data", lastRd, initVal(lineA(0) + 32'h14));

    // R5 all words of the line hit
    errs = 0;
    for (int w = 0; w < 32; w++) begin
      access(1'b0, lineA(0) + 32'(w * 4), 32'd0);
      if (rdBeats + wrBeats != 0 || lastRd !== initVal(lineA(0) + 32'(w * 4))) errs++;
    end
    chk("R5 hit sweep errors", 32'(errs), 32'd0);

    // R6 write hit
    access(1'b1, lineA(0) + 32'h10, 32'hCAFE_0010);
    expectBeats("R6 write hit no traffic", 0, 0);
    access(1'b0, lineA(0) + 32'h10, 32'd0);
    chk("R6 read after write hit", lastRd, 32'hCAFE_0010);
    chk("R6 external copy untouched", mem[idxOf(lineA(0) + 32'h10)], initVal(lineA(0) + 32'h10));

    // R8 fill remaining ways of set 0
    for (int k = 1; k < 4; k++) begin
      access(1'b0, lineA(k) + 32'h4, 32'd0);
      expectBeats("R8 clean fill", 32, 0);
      chk("R8 fill data", lastRd, initVal(lineA(k) + 32'h4));
    end
    // R7 fifth line evicts dirty way 0
    access(1'b0, lineA(4), 32'd0);
    expectBeats("R7 dirty victim write back then fill", 32, 32);
    chk("R7 write back order errors", 32'(burstErrs(1'b1, wrBase, lineA(0))), 32'd0);
    chk("R7 dirty word reached memory", mem[idxOf(lineA(0) + 32'h10)], 32'hCAFE_0010);
    chk("R7 new line data", lastRd, initVal(lineA(4)));
    access(1'b0, lineA(1), 32'd0);
    expectBeats("R8 way1 still resident", 0, 0);
    access(1'b0, lineA(0) + 32'h10, 32'd0);
    expectBeats("R8 evicted line misses, clean victim", 32, 0);
    chk("R8 refetched dirty data", lastRd, 32'hCAFE_0010);
    access(1'b0, lineA(1), 32'd0);
    expectBeats("R8 round robin evicted way1", 32, 0);

    // R9 freeze: set 0 now holds lines 4, 0, 1, 3
    setMode(2'd1);
    chk("R9 mode freeze", 32'(modeOut), 32'd1);
    access(1'b0, lineA(2), 32'd0);
    expectBeats("R9 freeze read miss single", 1, 0);
    chk("R9 freeze miss data", lastRd, initVal(lineA(2)));
    access(1'b0, lineA(2), 32'd0);
    expectBeats("R9 freeze miss not allocated", 1, 0);
    access(1'b1, lineA(2), 32'h1111_2222);
    expectBeats("R9 freeze write miss through", 0, 1);
    chk("R9 write through data", mem[idxOf(lineA(2))], 32'h1111_2222);
    access(1'b0, lineA(3) + 32'h4, 32'd0);
    expectBeats("R9 freeze hit", 0, 0);
    access(1'b1, lineA(3) + 32'h8, 32'h3333_4444);
    expectBeats("R9 freeze write hit", 0, 0);
    access(1'b0, lineA(3) + 32'h8, 32'd0);
    chk("R9 freeze write hit data", lastRd, 32'h3333_4444);
    access(1'b0, lineA(4), 32'd0);
    expectBeats("R9 freeze evicted nothing", 0, 0);

    // R10 bypass
    setMode(2'd2);
    access(1'b0, lineA(3) + 32'h8, 32'd0);
    expectBeats("R10 bypass read external", 1, 0);
    chk("R10 bypass returns memory copy", lastRd, initVal(lineA(3) + 32'h8));
    access(1'b0, lineA(4), 32'd0);
    expectBeats("R10 bypass ignores resident line", 1, 0);
    access(1'b1, lineA(0) + 32'h20, 32'h5555_6666);
    expectBeats("R10 bypass write external", 0, 1);
    chk("R10 bypass write data", mem[idxOf(lineA(0) + 32'h20)], 32'h5555_6666);
    setMode(2'd0);
    access(1'b0, lineA(3) + 32'h8, 32'd0);
    expectBeats("R10 contents kept after bypass", 0, 0);
    chk("R10 dirty data kept", lastRd, 32'h3333_4444);

    // R11 illegal mode ignored
    setMode(2'd3);
    chk("R11 mode 3 ignored", 32'(modeOut), 32'd0);
    access(1'b0, lineA(1) + 32'h8, 32'd0);
    expectBeats("R11 still normal", 0, 0);

    // R3 uncacheable region 0x42
    access(1'b1, 32'h4200_0100, 32'h7777_8888);
    expectBeats("R3 uncacheable write single", 0, 1);
    chk("R3 uncacheable write data", mem[idxOf(32'h4200_0100)], 32'h7777_8888);
    access(1'b0, 32'h4200_0100, 32'd0);
    expectBeats("R3 uncacheable read single", 1, 0);
    chk("R3 uncacheable read data", lastRd, 32'h7777_8888);
    access(1'b0, 32'h4200_0100, 32'd0);
    expectBeats("R3 uncacheable not allocated", 1, 0);
    chk("R12 handshake word address", rdLog[(rdTotal - 1) % 64], 32'h4200_0100);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule